// File: doc/BRIEF.md
# Per-Pin Interrupt Condition Detector

This block sits between the pin synchronizers and the pending-interrupt status register of a general-purpose I/O controller. Every clock cycle it looks at the synchronized level of each pin, compares it with the level that pin had in the previous cycle, and decides for each pin whether the status bit should be set. The decision is taken per pin from that pin's direction bit, a two-bit trigger code and an any-edge override bit.

The trigger code selects one of four conditions. Level conditions (low or high) request continuously for as long as the level is present, so a status bit cleared by software is set again while the level persists. Edge conditions (rising or falling) request for exactly one cycle. The any-edge bit replaces the code with "any change". Pins driven as outputs never request. The set-request vector is combinational from the current levels and the stored previous levels; only the previous-level history is registered.

Top module: `pin_irq_detect`

## Requirements
- R1: A pin whose direction bit is 1 (output) never asserts its set request, whatever its level, code or any-edge bit.
- R2: On an input pin with the any-edge bit set, the request is asserted exactly when the current level differs from the previous level; the trigger code has no effect.
- R3: Code 00 (level low) on an input pin without any-edge asserts the request in every cycle in which the current level is 0, and in no other cycle.
- R4: Code 01 (level high) on an input pin without any-edge asserts the request in every cycle in which the current level is 1, and in no other cycle.
- R5: Code 10 (rising edge) asserts the request only in the cycle where the previous level is 0 and the current level is 1.
- R6: Code 11 (falling edge) asserts the request only in the cycle where the previous level is 1 and the current level is 0.
- R7: Pin n takes its code from bits 2n+1 (1 = edge, 0 = level) and 2n (the level that triggers in level mode; in edge mode the level the pin leaves) of the 64-bit code vector.
- R8: The previous-level history captures all current levels at every clock edge and is cleared to all zeros by synchronous reset; the request responds in the same cycle the level is presented.
- R9: The request of each pin depends only on that pin's own level, history and configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 32 | Synchronized current pin levels |
| dir_out | input | 32 | Per-pin direction, 1 = output |
| any_edge | input | 32 | Per-pin any-change override |
| trig_code | input | 64 | Two code bits per pin, pin n at bits 2n+1:2n |
| set_req | output | 32 | Per-pin request to set the pending status bit |

## Verification
The any-edge override and the two-bit code are both evaluated for the same pin in the same cycle, so the interesting collision is a transition the code would reject while the override accepts it, or a steady level the code would accept while the override rejects it. The bench provokes this by pairing the override with a rising-edge code on a falling transition and with a level-low code on a steady low level, and judges the request against a model that gives the override priority. A second collision, reset and a pin change in the same cycle, is provoked by raising all pins with any-edge set while reset is held, expecting a request on every pin because the history reads zero.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int CODE_BITS = 2;

    typedef enum logic [CODE_BITS-1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic       is_out;
        logic       any_edge;
        trig_mode_e mode;
    } pin_cfg_t;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_lvl_t;

    // Trigger decision for one pin.
    function automatic logic trig_hit(pin_cfg_t cfg, pin_lvl_t lv);
        logic moved;
        logic hit;
        moved = lv.cur ^ lv.prev;
        if (cfg.is_out) begin
            hit = 1'b0;
        end else if (cfg.any_edge) begin
            hit = moved;
        end else begin
            case (cfg.mode)
                TRIG_LOW:  hit = ~lv.cur;
                TRIG_HIGH: hit = lv.cur;
                TRIG_RISE: hit = moved & lv.cur;
                TRIG_FALL: hit = moved & ~lv.cur;
                default:   hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/pin_hist_reg.sv
module pin_hist_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] lvl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_in;
        end
    end

    // R8: history is cleared by reset
    assert_hist_clear_R8: assert property (@(posedge clk)
        rst |=> (lvl_q == '0))
        else $error("history not cleared by reset");

    // R8: history follows the inputs one edge later
    assert_hist_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (lvl_q == $past(lvl_in)))
        else $error("history did not capture levels");

endmodule

// File: rtl/pin_trig_cell.sv
module pin_trig_cell
    import pin_irq_pkg::*;
(
    input  pin_cfg_t cfg,
    input  pin_lvl_t lv,
    output logic     req
);

    always_comb begin
        req = trig_hit(cfg, lv);
    end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int CODE_W  = NUM_PINS * CODE_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] dir_out,
    input  logic [NUM_PINS-1:0] any_edge,
    input  logic [CODE_W-1:0]   trig_code,
    output logic [NUM_PINS-1:0] set_req
);

    logic [NUM_PINS-1:0] prev_lvl;
    logic [NUM_PINS-1:0] edge_sel;
    logic [NUM_PINS-1:0] pol_sel;

    pin_hist_reg #(.WIDTH(NUM_PINS)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (pin_lvl),
        .lvl_q  (prev_lvl)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg;
        pin_lvl_t lv;
        assign edge_sel[i] = trig_code[CODE_BITS*i + 1];
        assign pol_sel[i]  = trig_code[CODE_BITS*i];
        assign cfg.is_out   = dir_out[i];
        assign cfg.any_edge = any_edge[i];
        assign cfg.mode     = trig_mode_e'(trig_code[CODE_BITS*i +: CODE_BITS]);
        assign lv.cur       = pin_lvl[i];
        assign lv.prev      = prev_lvl[i];

        pin_trig_cell u_cell (
            .cfg (cfg),
            .lv  (lv),
            .req (set_req[i])
        );
    end

    // R1: outputs stay quiet
    assert_out_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (set_req & dir_out) == '0)
        else $error("output pin requested");

    // R2: override never requests without a change
    assert_any_still_R2: assert property (@(posedge clk) disable iff (rst)
        (set_req & ~dir_out & any_edge & ~(pin_lvl ^ prev_lvl)) == '0)
        else $error("any-edge request without change");

    // R3 / R4: a matching level always requests
    assert_level_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (~set_req & ~dir_out & ~any_edge & ~edge_sel & ~(pin_lvl ^ pol_sel)) == '0)
        else $error("level match without request");

    // R5 / R6: edge codes only fire on a change
    assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (set_req & ~any_edge & edge_sel & ~(pin_lvl ^ prev_lvl)) == '0)
        else $error("edge request without change");

endmodule

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int NV = 16;

    // {dir, any, code1, code0, prev, cur, expected}
    localparam logic [6:0] VEC [NV] = '{
        7'b0000001, 7'b0000110, 7'b0001111, 7'b0001000,
        7'b0010011, 7'b0010100, 7'b0010110, 7'b0011101,
        7'b0011010, 7'b0011000, 7'b0110101, 7'b0100000,
        7'b0101101, 7'b1000000, 7'b1110010, 7'b1001110
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   pin_lvl  = '0;
    logic [N-1:0]   dir_out  = '0;
    logic [N-1:0]   any_edge = '0;
    logic [2*N-1:0] trig_code = '0;
    logic [N-1:0]   set_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_detect i_pin_irq_detect (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .dir_out(dir_out),
        .any_edge(any_edge), .trig_code(trig_code), .set_req(set_req)
    );

    function automatic logic ref_bit(logic d, logic a, logic c1, logic c0,
                                     logic p, logic c);
        if (d) return 1'b0;
        if (a) return p ^ c;
        if (c1) return (p ^ c) & (c ^ c0);
        return c == c0;
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        // R8: reset clears history; raised pins with any-edge see a change
        pin_lvl = '1; any_edge = '1; dir_out = '0;
        @(negedge clk); @(negedge clk);
        check("R8 reset history zero", set_req, '1);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R8 history captured after reset, R2 steady", set_req, '0);

        // Table walk: one pin under test, others outputs (R1, R7, R9)
        for (int k = 0; k < NV; k++) begin
            int p;
            logic [6:0] v;
            p = (k * 7) % N;
            v = VEC[k];
            @(negedge clk);
            dir_out = '1; dir_out[p] = v[6];
            any_edge = '0; any_edge[p] = v[5];
            trig_code = '0; trig_code[2*p+1] = v[4]; trig_code[2*p] = v[3];
            pin_lvl = '0; pin_lvl[p] = v[2];
            @(negedge clk);
            pin_lvl[p] = v[1];
            #1;
            check($sformatf("R1-R7 table entry %0d pin %0d (R2 R3 R4 R5 R6 R7)", k, p),
                  set_req, {{(N-1){1'b0}}, v[0]} << p);
        end

        // R4 level held across cycles, R5 pulse lasts one cycle
        @(negedge clk);
        dir_out = '0; any_edge = '0; pin_lvl = '0;
        for (int i = 0; i < N; i++) trig_code[2*i +: 2] = (i < 16) ? 2'b01 : 2'b10;
        @(negedge clk);
        pin_lvl = '1; #1;
        check("R4 R5 first cycle of high", set_req, '1);
        @(negedge clk); #1;
        check("R4 level held, R5 pulse gone", set_req, 32'h0000_FFFF);
        @(negedge clk); #1;
        check("R4 level still held", set_req, 32'h0000_FFFF);
        // R6 falling and R3 low
        for (int i = 0; i < N; i++) trig_code[2*i +: 2] = (i < 16) ? 2'b00 : 2'b11;
        pin_lvl = '0; #1;
        check("R3 R6 falling cycle", set_req, '1);
        @(negedge clk); #1;
        check("R3 held, R6 pulse gone", set_req, 32'h0000_FFFF);

        // R9 random mixed configurations against the model
        begin
            logic [N-1:0] last;
            last = pin_lvl;
            for (int t = 0; t < 80; t++) begin
                logic [N-1:0] exp;
                @(negedge clk);
                lfsr = next_rand(lfsr); pin_lvl = lfsr;
                lfsr = next_rand(lfsr); dir_out = lfsr;
                lfsr = next_rand(lfsr); dir_out = dir_out & lfsr;
                lfsr = next_rand(lfsr); any_edge = lfsr & next_rand(lfsr);
                lfsr = next_rand(lfsr); trig_code[31:0] = lfsr;
                lfsr = next_rand(lfsr); trig_code[63:32] = lfsr;
                #1;
                for (int i = 0; i < N; i++)
                    exp[i] = ref_bit(dir_out[i], any_edge[i], trig_code[2*i+1],
                                     trig_code[2*i], last[i], pin_lvl[i]);
                check($sformatf("R9 mixed cycle %0d", t), set_req, exp);
                last = pin_lvl;
            end
        end
        report();
    end
endmodule